// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects level-sensitive interrupt requests from two groups of sources and presents one service request line to a processor. The primary group has 40 lines. Line 0 of that group has no pin of its own: it stands for the whole secondary group of 32 sources, which is ORed onto it. Each source has a sticky pending bit and an enable bit. Enables are changed through separate write-one-to-set and write-one-to-clear words. Pending bits are cleared through a write-one acknowledge word.

Software reaches the block through a plain 32-bit register port with a word address, a write strobe, write data and combinational read data. When it is interrupted, software reads the index word. A nonzero value is the number of the lowest-numbered enabled pending primary line. A value of zero sends it to the secondary status word, where the lowest set bit names the secondary source. The block also holds one small routing entry per primary source, which software may read and write freely.

Top module: `cic_irq_ctrl`

## Requirements
- R1: After reset every enable bit and every pending bit is zero, irq_out is low, every channel-map entry reads zero, and the index word at byte 0x40 reads zero.
- R2: A primary source that is high at a clock edge sets its pending bit at that edge. The bit then holds after the source drops. Primary pending bits read at 0x10 (sources 0..31, bit n = source n) and 0x14 (sources 32..39 in bits 7:0). Secondary pending bits read raw at 0x88 (bit n = secondary source n) and behave the same way.
- R3: Writing 1 to a bit of an acknowledge word (0x10/0x14 primary, 0x88 secondary) clears that pending bit at the write edge, and bits written 0 leave their bits alone. If the source is still high, the bit sets again at the following edge.
- R4: Writing 1s to 0x20/0x24 (primary) or 0x90 (secondary) sets those enable bits, and writing 1s to 0x30/0x34 or 0x98 clears them. Bits written 0 change nothing. Both words of a set/clear pair read back the current enable mask.
- R5: Primary bit 0 reads as pending exactly while some secondary bit is both pending and enabled. An acknowledge of primary bit 0 has no effect on it.
- R6: irq_out is high exactly while some primary line is both pending (bit 0 as in R5) and enabled.
- R7: The word at 0x40 returns, in bits 5:0, the lowest-numbered primary line from 1 to 39 that is pending and enabled, and 0 if there is none. Line 0 never outranks another line, and bits 31:6 read zero.
- R8: The word at 0x80 returns the secondary pending bits ANDed with the secondary enables.
- R9: In the second primary word only bits 7:0 (sources 32..39) exist. Written upper bits are ignored and read as zero.
- R10: Channel-map entry i (0..39) lives at byte 0x200 + 4*i and stores bits 7:0 of the written data. It reads back zero-extended, and addresses at or above 0x2A0 read zero.
- R11: The word at 0x44 and every other unmapped address read zero. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pri_src | input | 39 | Primary source levels; bit k is primary line k+1 |
| sec_src | input | 32 | Secondary source levels |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Service request to the processor |

## Verification
Every register effect happens at a single rising edge. Source levels and write strobes present at an edge change the pending bits, enables and channel map at that edge. irq_out and all read data follow that state with no further delay, and a second edge is needed only when a source re-sets its pending bit after an acknowledge. The bench therefore drives inputs on the falling edge and lets one rising edge pass. It then samples irq_out and the read data one nanosecond after the next falling edge, comparing them with a model updated at that same rising edge. The re-set case is checked on both sides of the extra edge.

// File: rtl/cic_pkg.sv
package cic_pkg;

   // Word addresses (byte address / 4) of the register kinds.
   localparam int WA_PRI_ACK  = 'h004;
   localparam int WA_PRI_SET  = 'h008;
   localparam int WA_PRI_CLR  = 'h00C;
   localparam int WA_INDEX    = 'h010;
   localparam int WA_STATUS   = 'h011;
   localparam int WA_SEC_STAT = 'h020;
   localparam int WA_SEC_ACK  = 'h022;
   localparam int WA_SEC_SET  = 'h024;
   localparam int WA_SEC_CLR  = 'h026;
   localparam int WA_CHMAP    = 'h080;

   // Words reserved for each primary register kind.
   localparam int PRI_KIND_WORDS = 4;

endpackage

// File: rtl/cic_wr_decode.sv
module cic_wr_decode #(
   parameter int N        = 40,
   parameter int DATA_W   = 32,
   parameter int WA_W     = 10,
   parameter int BASE_ACK = 4,
   parameter int BASE_SET = 8,
   parameter int BASE_CLR = 12
) (
   input  logic              wr,
   input  logic [WA_W-1:0]   waddr,
   input  logic [DATA_W-1:0] wdata,
   output logic [N-1:0]      ack_m,
   output logic [N-1:0]      set_m,
   output logic [N-1:0]      clr_m
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      localparam int WORD = i / DATA_W;
      localparam int BIT  = i % DATA_W;
      assign ack_m[i] = wr && (waddr == WA_W'(BASE_ACK + WORD)) && wdata[BIT];
      assign set_m[i] = wr && (waddr == WA_W'(BASE_SET + WORD)) && wdata[BIT];
      assign clr_m[i] = wr && (waddr == WA_W'(BASE_CLR + WORD)) && wdata[BIT];
   end

endmodule

// File: rtl/cic_src_bank.sv
module cic_src_bank #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src,
   input  logic [N-1:0] ack_m,
   input  logic [N-1:0] set_m,
   input  logic [N-1:0] clr_m,
   output logic [N-1:0] pend,
   output logic [N-1:0] en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         en   <= '0;
      end else begin
         pend <= (pend | src) & ~ack_m;
         en   <= (en | set_m) & ~clr_m;
      end
   end

endmodule

// File: rtl/cic_lowest_enc.sv
module cic_lowest_enc #(
   parameter int N     = 39,
   parameter int IDX_W = 6
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx
);

   // req[k] stands for line k+1; no request yields 0.
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i + 1);
      end
   end

endmodule

// File: rtl/cic_chan_map.sv
module cic_chan_map #(
   parameter int ENTRIES = 40,
   parameter int ENT_W   = 8,
   parameter int WA_W    = 10,
   parameter int BASE    = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WA_W-1:0]  waddr,
   input  logic [ENT_W-1:0] wdata,
   output logic             hit,
   output logic [ENT_W-1:0] rdata
);

   logic [ENTRIES-1:0][ENT_W-1:0] entry;
   logic [WA_W-1:0]               rel;

   assign rel = waddr - WA_W'(BASE);
   assign hit = (waddr >= WA_W'(BASE)) && (rel < WA_W'(ENTRIES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry <= '0;
      end else if (wr && hit) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (rel == WA_W'(e)) entry[e] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (hit && rel == WA_W'(e)) rdata = entry[e];
      end
   end

endmodule

// File: rtl/cic_irq_ctrl.sv
module cic_irq_ctrl #(
   parameter int PRI_N   = 40,
   parameter int SEC_N   = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter int CHMAP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PRI_N-2:0]  pri_src,
   input  logic [SEC_N-1:0]  sec_src,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);
   import cic_pkg::*;

   localparam int WA_W      = ADDR_W - 2;
   localparam int PRI_WORDS = (PRI_N + DATA_W - 1) / DATA_W;
   localparam int PRI_PAD   = PRI_WORDS * DATA_W;
   localparam int IDX_W     = $clog2(PRI_N);

   // Elaboration-time parameter checks.
   if (PRI_N < 2 || PRI_WORDS > PRI_KIND_WORDS) begin : g_bad_pri
      $error("cic_irq_ctrl: PRI_N out of range");
   end
   if (SEC_N < 1 || SEC_N > DATA_W) begin : g_bad_sec
      $error("cic_irq_ctrl: SEC_N must fit one data word");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("cic_irq_ctrl: register map assumes 32-bit words");
   end
   if (CHMAP_W < 1 || CHMAP_W > DATA_W || IDX_W > DATA_W) begin : g_bad_w
      $error("cic_irq_ctrl: field width out of range");
   end
   if (WA_CHMAP + PRI_N > (1 << WA_W)) begin : g_bad_addr
      $error("cic_irq_ctrl: ADDR_W too small for channel map");
   end

   logic [WA_W-1:0] waddr;
   logic            unused_lsb;
   assign waddr      = reg_addr[ADDR_W-1:2];
   assign unused_lsb = ^reg_addr[1:0];

   // Primary group.
   logic [PRI_N-1:0] pri_ack_m, pri_set_m, pri_clr_m;
   logic [PRI_N-1:0] pri_pend, pri_en, pri_pend_eff;

   cic_wr_decode #(
      .N(PRI_N), .DATA_W(DATA_W), .WA_W(WA_W),
      .BASE_ACK(WA_PRI_ACK), .BASE_SET(WA_PRI_SET), .BASE_CLR(WA_PRI_CLR)
   ) u_pri_dec (
      .wr(reg_wr), .waddr(waddr), .wdata(reg_wdata),
      .ack_m(pri_ack_m), .set_m(pri_set_m), .clr_m(pri_clr_m)
   );

   cic_src_bank #(.N(PRI_N)) u_pri_bank (
      .clk(clk), .rst_n(rst_n), .src({pri_src, 1'b0}),
      .ack_m(pri_ack_m), .set_m(pri_set_m), .clr_m(pri_clr_m),
      .pend(pri_pend), .en(pri_en)
   );

   // Secondary group.
   logic [SEC_N-1:0] sec_ack_m, sec_set_m, sec_clr_m;
   logic [SEC_N-1:0] sec_pend, sec_en;
   logic             cascade;

   cic_wr_decode #(
      .N(SEC_N), .DATA_W(DATA_W), .WA_W(WA_W),
      .BASE_ACK(WA_SEC_ACK), .BASE_SET(WA_SEC_SET), .BASE_CLR(WA_SEC_CLR)
   ) u_sec_dec (
      .wr(reg_wr), .waddr(waddr), .wdata(reg_wdata),
      .ack_m(sec_ack_m), .set_m(sec_set_m), .clr_m(sec_clr_m)
   );

   cic_src_bank #(.N(SEC_N)) u_sec_bank (
      .clk(clk), .rst_n(rst_n), .src(sec_src),
      .ack_m(sec_ack_m), .set_m(sec_set_m), .clr_m(sec_clr_m),
      .pend(sec_pend), .en(sec_en)
   );

   // Cascade onto primary line 0 (its own latch never sets).
   assign cascade      = |(sec_pend & sec_en);
   assign pri_pend_eff = {pri_pend[PRI_N-1:1], pri_pend[0] | cascade};
   assign irq_out      = |(pri_pend_eff & pri_en);

   // Priority index.
   logic [IDX_W-1:0] prio_idx;

   cic_lowest_enc #(.N(PRI_N - 1), .IDX_W(IDX_W)) u_enc (
      .req(pri_pend_eff[PRI_N-1:1] & pri_en[PRI_N-1:1]),
      .idx(prio_idx)
   );

   // Channel map.
   logic               map_hit;
   logic [CHMAP_W-1:0] map_rdata;

   cic_chan_map #(
      .ENTRIES(PRI_N), .ENT_W(CHMAP_W), .WA_W(WA_W), .BASE(WA_CHMAP)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(waddr),
      .wdata(reg_wdata[CHMAP_W-1:0]), .hit(map_hit), .rdata(map_rdata)
   );

   // Read mux.
   logic [PRI_PAD-1:0] pend_pad, en_pad;
   assign pend_pad = PRI_PAD'(pri_pend_eff);
   assign en_pad   = PRI_PAD'(pri_en);

   always_comb begin
      reg_rdata = '0;
      for (int w = 0; w < PRI_WORDS; w++) begin
         if (waddr == WA_W'(WA_PRI_ACK + w))
            reg_rdata = pend_pad[w*DATA_W +: DATA_W];
         if (waddr == WA_W'(WA_PRI_SET + w) || waddr == WA_W'(WA_PRI_CLR + w))
            reg_rdata = en_pad[w*DATA_W +: DATA_W];
      end
      if (waddr == WA_W'(WA_INDEX))    reg_rdata = DATA_W'(prio_idx);
      if (waddr == WA_W'(WA_SEC_STAT)) reg_rdata = DATA_W'(sec_pend & sec_en);
      if (waddr == WA_W'(WA_SEC_ACK))  reg_rdata = DATA_W'(sec_pend);
      if (waddr == WA_W'(WA_SEC_SET) || waddr == WA_W'(WA_SEC_CLR))
         reg_rdata = DATA_W'(sec_en);
      if (map_hit) reg_rdata = DATA_W'(map_rdata);
   end

endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
   parameter int PRI_N = 40,
   parameter int SEC_N = 32,
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_out,
   input logic [IDX_W-1:0] idx,
   input logic [PRI_N-1:0] pri_pend_eff,
   input logic [PRI_N-1:0] pri_en,
   input logic [SEC_N-1:0] sec_src,
   input logic [SEC_N-1:0] sec_pend,
   input logic [SEC_N-1:0] sec_en,
   input logic [SEC_N-1:0] sec_ack_m,
   input logic [SEC_N-1:0] sec_set_m
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (($past(sec_src) & ~$past(sec_ack_m) & ~sec_pend) == '0));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (($past(sec_pend) & ~$past(sec_ack_m) & ~sec_pend) == '0));

   assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((sec_pend & $past(sec_ack_m)) == '0));

   assert_enable_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (($past(sec_set_m) & ~sec_en) == '0));

   assert_cascade_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(sec_pend & sec_en)) && pri_en[0]) |-> irq_out);

   assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (|pri_en));

   assert_index_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (idx != '0) |-> (pri_pend_eff[idx] && pri_en[idx] && irq_out));

endmodule

bind cic_irq_ctrl cic_checker #(
   .PRI_N(PRI_N), .SEC_N(SEC_N), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .idx(prio_idx),
   .pri_pend_eff(pri_pend_eff), .pri_en(pri_en), .sec_src(sec_src),
   .sec_pend(sec_pend), .sec_en(sec_en), .sec_ack_m(sec_ack_m),
   .sec_set_m(sec_set_m)
);

// File: tb/sim_cic_irq_ctrl.sv
module sim_cic_irq_ctrl;
   localparam int PN = 40;
   localparam int SN = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PN-2:0] psrc = '0;
   logic [SN-1:0] ssrc = '0;
   logic [11:0]   addr = '0;
   logic          wr = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;

   always #5 clk = ~clk;

   cic_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pri_src(psrc), .sec_src(ssrc),
      .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
      .reg_rdata(rdata), .irq_out(irq)
   );

   int n_chk = 0;
   int n_err = 0;

   // Bench model of the register state.
   logic [PN-1:0] m_pp = '0, m_pe = '0;
   logic [SN-1:0] m_sp = '0, m_se = '0;
   logic [PN-1:0][7:0] m_map = '0;

   function automatic logic [PN-1:0] m_eff();
      return {m_pp[PN-1:1], |(m_sp & m_se)};
   endfunction

   function automatic logic m_irq();
      return |(m_eff() & m_pe);
   endfunction

   function automatic logic [31:0] m_idx();
      logic [PN-1:0] r = m_eff() & m_pe;
      for (int i = 1; i < PN; i++) if (r[i]) return 32'(i);
      return 32'd0;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One rising edge with the current inputs; model follows the requirements.
   task automatic tick();
      logic [PN-1:0] ack = '0, set = '0, clr = '0;
      logic [SN-1:0] sack = '0, sset = '0, sclr = '0;
      logic [11:0]   a = {addr[11:2], 2'b00};
      if (wr) begin
         case (a)
            12'h010: ack[31:0]  = wdata;
            12'h014: ack[39:32] = wdata[7:0];
            12'h020: set[31:0]  = wdata;
            12'h024: set[39:32] = wdata[7:0];
            12'h030: clr[31:0]  = wdata;
            12'h034: clr[39:32] = wdata[7:0];
            12'h088: sack = wdata;
            12'h090: sset = wdata;
            12'h098: sclr = wdata;
            default: ;
         endcase
      end
      @(posedge clk);
      m_pp = ((m_pp | {psrc, 1'b0}) & ~ack) & ~PN'(1);
      m_pe = (m_pe | set) & ~clr;
      m_sp = (m_sp | ssrc) & ~sack;
      m_se = (m_se | sset) & ~sclr;
      if (wr && a >= 12'h200 && a < 12'h2A0) m_map[(a - 12'h200) >> 2] = wdata[7:0];
      @(negedge clk);
   endtask

   task automatic wrt(logic [11:0] a, logic [31:0] d);
      addr = a; wdata = d; wr = 1'b1;
      tick();
      wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, string req, logic [31:0] exp);
      addr = a;
      #1;
      check(req, rdata, exp);
   endtask

   task automatic chk_all(string tag);
      #1;
      check({tag, " R6 irq"}, 32'(irq), 32'(m_irq()));
      rd(12'h040, {tag, " R7 index"}, m_idx());
      rd(12'h080, {tag, " R8 sec status"}, m_sp & m_se);
      rd(12'h088, {tag, " R2 sec pend"}, m_sp);
      rd(12'h010, {tag, " R5 pri pend lo"}, m_eff()[31:0]);
      rd(12'h014, {tag, " R9 pri pend hi"}, 32'(m_eff()[39:32]));
      rd(12'h024, {tag, " R4 pri en hi"}, 32'(m_pe[39:32]));
   endtask

   initial begin
      void'($urandom(32'd20241));
      repeat (3) @(negedge clk);
      #1;
      check("R1 irq after reset", 32'(irq), 32'd0);
      rd(12'h040, "R1 index after reset", 32'd0);
      rd(12'h010, "R1 pending after reset", 32'd0);
      rd(12'h020, "R1 enable after reset", 32'd0);
      rd(12'h090, "R1 sec enable after reset", 32'd0);
      rd(12'h21C, "R1 chmap after reset", 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: latch and hold with enables off.
      psrc[4] = 1'b1; tick(); psrc[4] = 1'b0; tick();
      rd(12'h010, "R2 latch holds", 32'h20);
      check("R6 masked source keeps irq low", 32'(irq), 32'd0);
      wrt(12'h020, 32'h20);
      #1; check("R6 enabled pending raises irq", 32'(irq), 32'd1);
      rd(12'h040, "R7 index single", 32'd5);
      wrt(12'h020, 32'h0);
      rd(12'h030, "R4 zero bits no effect", 32'h20);
      psrc[2] = 1'b1; wrt(12'h020, 32'h8);
      rd(12'h040, "R7 lower number wins", 32'd3);

      // R3: acknowledge with source still high, then re-set.
      wrt(12'h010, 32'h28);
      rd(12'h010, "R3 ack clears", 32'h0);
      tick();
      rd(12'h010, "R3 re-set while source high", 32'h8);
      psrc[2] = 1'b0;
      wrt(12'h010, 32'h8);
      wrt(12'h030, 32'h28);
      rd(12'h020, "R4 clear enables", 32'h0);

      // R9: upper word has eight bits.
      wrt(12'h024, 32'hFFFF_FFFF);
      rd(12'h024, "R9 upper enable bits ignored", 32'hFF);
      psrc[38] = 1'b1; tick(); psrc[38] = 1'b0;
      rd(12'h014, "R9 source 39 pending", 32'h80);
      rd(12'h040, "R7 index 39", 32'd39);
      wrt(12'h014, 32'hFFFF_FF00);
      rd(12'h014, "R9 upper ack bits ignored", 32'h80);
      wrt(12'h014, 32'hFF);
      wrt(12'h034, 32'hFF);

      // R5/R8: cascade path.
      ssrc[7] = 1'b1; ssrc[9] = 1'b1; tick(); ssrc = '0;
      rd(12'h088, "R2 sec latch", 32'h280);
      rd(12'h080, "R8 masked sec status", 32'h0);
      rd(12'h010, "R5 no cascade without sec enable", 32'h0);
      wrt(12'h090, 32'h80);
      rd(12'h080, "R8 sec status enabled", 32'h80);
      rd(12'h010, "R5 cascade pending", 32'h1);
      check("R6 cascade needs primary enable", 32'(irq), 32'd0);
      wrt(12'h020, 32'h1);
      #1; check("R5 cascade raises irq", 32'(irq), 32'd1);
      rd(12'h040, "R7 index zero for cascade", 32'd0);
      wrt(12'h010, 32'h1);
      rd(12'h010, "R5 primary ack of line 0 ignored", 32'h1);
      wrt(12'h088, 32'h80);
      rd(12'h080, "R3 sec ack", 32'h0);
      #1; check("R6 irq drops", 32'(irq), 32'd0);
      wrt(12'h098, 32'h80);
      rd(12'h090, "R4 sec clear", 32'h0);
      wrt(12'h088, 32'h200);

      // R10/R11.
      wrt(12'h200, 32'hABCD_1234);
      wrt(12'h29C, 32'h0000_00C5);
      rd(12'h200, "R10 entry 0", 32'h34);
      rd(12'h29E, "R11 low address bits ignored", 32'hC5);
      rd(12'h2A0, "R10 beyond map", 32'h0);
      rd(12'h044, "R11 status word zero", 32'h0);
      rd(12'h0FC, "R11 unmapped zero", 32'h0);

      // Random phase.
      for (int it = 0; it < 400; it++) begin
         int op = int'($urandom_range(0, 11));
         psrc = ($urandom() & $urandom() & $urandom()) | (39'($urandom() & $urandom() & 32'h0F) << 32);
         ssrc = $urandom() & $urandom() & $urandom();
         wdata = $urandom();
         case (op)
            0: addr = 12'h010; 1: addr = 12'h014; 2: addr = 12'h020;
            3: addr = 12'h024; 4: addr = 12'h030; 5: addr = 12'h034;
            6: addr = 12'h088; 7: addr = 12'h090; 8: addr = 12'h098;
            default: addr = 12'h040;
         endcase
         wr = (op < 9);
         tick();
         wr = 1'b0;
         chk_all("rand");
      end
      for (int e = 0; e < PN; e += 13) rd(12'(12'h200 + 4 * e), "R10 map readback", 32'(m_map[e]));

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #2_000_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule